// File: doc/BRIEF.md
# Light-Load Burst Sequencer

This block decides when a switching converter stops switching because its load has become very small, and when it starts again. It watches a digitised copy of the error-amplifier output, `ctrlCode`. In normal operation the turn-on controller may switch freely. When the code drops below the burst level by more than a hysteresis margin, the block withdraws the switching enable and raises a low-power flag.

While it rests in this state, a wake timer runs. The timer restarts on every entry into the rest state. When one full wake period has passed, the block asks the turn-on controller for a short probe pulse train and holds that request for a fixed window. It examines the control code only in the last cycle of the window. If the code is above the lower control level, normal switching resumes. If it is not, the block rests for another full wake period. The burst level, the hysteresis, the lower level, the wake period and the probe window length are all parameters.

Top module: `burst_seq`

## Requirements
- R1: After reset the block is in normal operation: `switchEn`=1, `probeReq`=0, `lowPower`=0.
- R2: In normal operation, a clock edge at which `ctrlCode` < BURST_CODE-HYST_CODE (unsigned) moves the block into rest. A code equal to or above that level keeps normal operation, including codes between that level and BURST_CODE.
- R3: In rest, `switchEn`=0, `probeReq`=0 and `lowPower`=1.
- R4: The wake timer restarts on each entry into rest. The block stays in rest for exactly WAKE_CYCLES clock cycles and then starts a probe window.
- R5: A probe window lasts exactly PROBE_CYCLES cycles. During the window `probeReq`=1, `switchEn`=0 and `lowPower`=1.
- R6: At the clock edge that ends the probe window, `ctrlCode` > LOW_CODE returns the block to normal operation. Otherwise the block enters rest again for a fresh WAKE_CYCLES period.
- R7: The value of `ctrlCode` has no effect on the outputs during rest or before the last cycle of a probe window, even when it is above LOW_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlCode | input | CODE_W | Digitised error-amplifier output, unsigned |
| switchEn | output | 1 | Enable to the turn-on controller |
| probeReq | output | 1 | Request for a probe pulse train |
| lowPower | output | 1 | Low-power status, high during rest and probe |

## Verification
Two functions can act on the same edge, or one right after the other. The exit decision at the end of a probe window can be followed at once by a new entry decision. This happens when the final probe code lies above LOW_CODE but below the entry level. The bench provokes this case with a code of LOW_CODE+1, held through the decision edge and the following edge. The scoreboard then expects exactly one cycle of normal operation, followed by a new rest period whose timer starts from zero. The bench judges this by counting cycles until the next probe window begins.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_REST  = 2'd1,
    ST_PROBE = 2'd2
  } seqState_t;

  typedef struct packed {
    logic timerRun;
    logic probeRun;
  } seqStrobe_t;

  typedef struct packed {
    logic belowEntry;
    logic aboveExit;
    logic wakeDone;
    logic probeDone;
  } seqFlags_t;
endpackage

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int BURST_CODE   = 100,
  parameter int HYST_CODE    = 7,
  parameter int LOW_CODE     = 70,
  parameter int WAKE_CYCLES  = 100000,
  parameter int PROBE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ctrlCode,
  input  seqStrobe_t        strobe,
  output seqFlags_t         flags
);
  localparam int WAKE_W  = $clog2(WAKE_CYCLES + 1);
  localparam int PROBE_W = $clog2(PROBE_CYCLES + 1);
  localparam logic [CODE_W-1:0]  ENTRY_CODE = CODE_W'(BURST_CODE - HYST_CODE);
  localparam logic [CODE_W-1:0]  EXIT_CODE  = CODE_W'(LOW_CODE);
  localparam logic [WAKE_W-1:0]  WAKE_LAST  = WAKE_W'(WAKE_CYCLES - 1);
  localparam logic [PROBE_W-1:0] PROBE_LAST = PROBE_W'(PROBE_CYCLES - 1);

  logic [WAKE_W-1:0]  wakeCnt;
  logic [PROBE_W-1:0] probeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wakeCnt <= '0;
    else if (!strobe.timerRun) wakeCnt <= '0;
    else if (wakeCnt != WAKE_LAST) wakeCnt <= wakeCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 probeCnt <= '0;
    else if (!strobe.probeRun) probeCnt <= '0;
    else if (probeCnt != PROBE_LAST) probeCnt <= probeCnt + 1'b1;
  end

  always_comb begin
    flags.belowEntry = (ctrlCode < ENTRY_CODE);
    flags.aboveExit  = (ctrlCode > EXIT_CODE);
    flags.wakeDone   = strobe.timerRun && (wakeCnt == WAKE_LAST);
    flags.probeDone  = strobe.probeRun && (probeCnt == PROBE_LAST);
  end

  // R4
  wake_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeCnt <= WAKE_LAST);

  // R4
  wake_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.timerRun && !$past(strobe.timerRun)) |-> (wakeCnt == '0));

  // R5
  probe_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeCnt <= PROBE_LAST);
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       switchEn,
  output logic       probeReq,
  output logic       lowPower
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (flags.belowEntry) stateNext = ST_REST;
      ST_REST:  if (flags.wakeDone)   stateNext = ST_PROBE;
      ST_PROBE: if (flags.probeDone)
                  stateNext = flags.aboveExit ? ST_RUN : ST_REST;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.timerRun = (state == ST_REST);
    strobe.probeRun = (state == ST_PROBE);
    switchEn        = (state == ST_RUN);
    probeReq        = (state == ST_PROBE);
    lowPower        = (state != ST_RUN);
  end

  // R2
  enter_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (switchEn && flags.belowEntry) |=> (lowPower && !switchEn && !probeReq));

  // R4
  rest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REST && !flags.wakeDone) |=> (lowPower && !probeReq));

  // R6
  probe_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeReq && flags.probeDone && flags.aboveExit) |=> (switchEn && !lowPower));

  // R7
  probe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeReq && !flags.probeDone) |=> probeReq);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int BURST_CODE   = 100,
  parameter int HYST_CODE    = 7,
  parameter int LOW_CODE     = 70,
  parameter int WAKE_CYCLES  = 100000,
  parameter int PROBE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ctrlCode,
  output logic              switchEn,
  output logic              probeReq,
  output logic              lowPower
);
  seqStrobe_t strobe;
  seqFlags_t  flags;

  burst_seq_dp #(
    .CODE_W(CODE_W), .BURST_CODE(BURST_CODE), .HYST_CODE(HYST_CODE),
    .LOW_CODE(LOW_CODE), .WAKE_CYCLES(WAKE_CYCLES), .PROBE_CYCLES(PROBE_CYCLES)
  ) dpInst (
    .clk(clk), .rstN(rstN), .ctrlCode(ctrlCode), .strobe(strobe), .flags(flags)
  );

  burst_seq_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .flags(flags), .strobe(strobe),
    .switchEn(switchEn), .probeReq(probeReq), .lowPower(lowPower)
  );
endmodule

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  localparam int CW = 8, BURST = 100, HYST = 7, LOW = 70, WAKE = 40, PROBE = 4;
  localparam int ENTRY = BURST - HYST;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] ctrlCode = '0;
  logic switchEn, probeReq, lowPower;

  int total = 0, bad = 0;
  bit finished = 0;
  bit [2:0] expQ[$];
  string tagQ[$];
  int mState = 0, mWake = 0, mProbe = 0;

  always #2.5 clk = ~clk;

  burst_seq #(.CODE_W(CW), .BURST_CODE(BURST), .HYST_CODE(HYST), .LOW_CODE(LOW),
              .WAKE_CYCLES(WAKE), .PROBE_CYCLES(PROBE)) uut (
    .clk(clk), .rstN(rstN), .ctrlCode(ctrlCode),
    .switchEn(switchEn), .probeReq(probeReq), .lowPower(lowPower));

  task automatic check(input string tag, input bit [2:0] act, input bit [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {sw,pr,lp} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: applies one code for one edge and predicts the outputs after it
  task automatic step(input int code);
    string tag;
    @(negedge clk);
    ctrlCode = CW'(code);
    case (mState)
      0: begin tag = "R2"; if (code < ENTRY) begin mState = 1; mWake = 0; end end
      1: begin
           tag = (code > LOW) ? "R7" : "R3";
           if (mWake == WAKE - 1) begin mState = 2; mProbe = 0; tag = "R4"; end
           else mWake++;
         end
      default: begin
           if (mProbe == PROBE - 1) begin
             tag = "R6";
             if (code > LOW) mState = 0; else begin mState = 1; mWake = 0; end
           end else begin
             tag = (code > LOW) ? "R7" : "R5";
             mProbe++;
           end
         end
    endcase
    expQ.push_back(mState == 0 ? 3'b100 : (mState == 1 ? 3'b001 : 3'b011));
    tagQ.push_back(tag);
  endtask

  task automatic run(input int code, input int n);
    for (int i = 0; i < n; i++) step(code);
  endtask

  // monitor: compares after each edge
  initial forever begin
    @(posedge clk);
    #1;
    if (expQ.size() > 0) check(tagQ.pop_front(), {switchEn, probeReq, lowPower}, expQ.pop_front());
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ctrlCode = 8'd120;
    repeat (3) @(negedge clk);
    check("R1", {switchEn, probeReq, lowPower}, 3'b100);
    rstN = 1'b1;
    run(120, 5);
    run(ENTRY, 4);          // R2 boundary: equal stays normal
    run(BURST - 2, 3);      // R2 hysteresis band
    run(ENTRY - 1, 1);      // R2 entry
    run(60, WAKE);          // R3/R4 rest then probe start
    run(90, PROBE - 1);     // R7 mid-window high code ignored
    run(LOW, 1);            // R6 boundary: equal stays off
    run(60, WAKE);
    run(90, PROBE - 1);
    run(LOW + 1, 1);        // R6 exit
    run(LOW + 1, 1);        // R2 immediate re-entry after exit
    run(110, WAKE);         // R7 high code during rest ignored
    run(110, PROBE - 1);
    run(120, 1);            // R6 exit
    run(120, 10);
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R5: pending actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule